// File: doc/BRIEF.md
# Bit-Banged Two-Wire Bus GPIO Window

This block gives software a tiny byte-addressed register window through which it drives a two-wire SMBus/I2C bus by hand. The window holds a 32-bit state word built from four bytes: a read-only sense byte, an output byte, a direction byte and a spare byte. A direction bit of 1 turns its line into an output. Each line is open-drain. The block can only pull a line low or let it float high. It pulls low only when the line's direction bit is 1 and its output bit is 0.

The bus levels come back through a multi-stage synchronizer. They are copied into the sense byte a fixed number of cycles after each effective write, which is a write that changes the byte it addresses. A write that leaves the stored byte unchanged changes nothing and does not refresh the sense byte. A small configuration side port places the window in I/O space. One configuration register holds a base address. Writing a key value to a second configuration register maps the window at base plus 0x38 and drops any earlier placement.

Top module: `smbus_gpio_port`

## Requirements
- R1: After reset the output, direction, spare and sense bytes are 0x00, both line drive enables are 0 and the window is unmapped (io_hit is 0).
- R2: A configuration write to offset 0x40 stores the base. A write of 0x00000011 to offset 0x44 maps the window at base+0x38 and replaces any earlier mapping. Other values at 0x44 leave the mapping unchanged, and a new base only takes effect at the next mapping write.
- R3: Inside the window, a read at offset 0 returns the sense byte, offset 1 the output byte, offset 2 the direction byte and offset 3 the spare byte. A write to offset 1, 2 or 3 is readable from the next cycle.
- R4: Writes to offset 0 are ignored, so the sense byte cannot be written.
- R5: A write whose byte equals the stored byte is not effective: all state is left as it was, including the sense byte.
- R6: The SDA drive enable line_oe[0] is 1 only when direction bit 0 (state bit 16) is 1 and output bit 0 (state bit 8) is 0.
- R7: The SCL drive enable line_oe[1] is 1 only when direction bit 1 (state bit 17) is 1 and output bit 1 (state bit 9) is 0.
- R8: The sense byte holds the synchronized SDA level in bit 0 and the SCL level in bit 1, with bits 7:2 at zero. It is refreshed on the third clock edge after an effective write and holds its value at all other times.
- R9: The decoded range is 8 bytes long. Offsets 4 to 7 have io_hit at 1, read as 0xFF and ignore writes.
- R10: Outside the decoded range, or while the window is unmapped, io_hit is 0, io_rdata is 0x00 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| io_addr | input | ADDR_W (32) | I/O byte address |
| io_rd | input | 1 | Byte read strobe |
| io_we | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Byte write data |
| io_rdata | output | 8 | Byte read data, valid in the same cycle as io_rd |
| io_hit | output | 1 | Address falls inside the mapped decoded range |
| line_in | input | LINES (2) | Sensed bus levels, bit 0 SDA, bit 1 SCL |
| line_oe | output | LINES (2) | Pull-low enables, bit 0 SDA, bit 1 SCL |

## Verification
Read data and io_hit are combinational, so they are due in the same cycle the bench raises io_rd. The bench samples them at the falling edge of that cycle. Byte writes and drive enables settle one edge after the write strobe is sampled. The sense byte refreshes on the third edge after an effective write, so the bench waits at least three further edges before it reads offset 0. Every expected item goes into a scoreboard queue when its stimulus is applied. The monitor pops and compares it at the falling edge on which the result is due.

// File: rtl/smbgp_pkg.sv
package smbgp_pkg;
   localparam logic [7:0]  CFG_BASE_REG = 8'h40;
   localparam logic [7:0]  CFG_MAP_REG  = 8'h44;
   localparam logic [31:0] MAP_KEY      = 32'h0000_0011;
   localparam logic [31:0] WIN_OFFSET   = 32'h0000_0038;

   typedef enum logic [1:0] {
      SEL_SENSE = 2'd0,
      SEL_OUT   = 2'd1,
      SEL_DIR   = 2'd2,
      SEL_SPARE = 2'd3
   } byte_sel_e;
endpackage

// File: rtl/smbgp_window.sv
module smbgp_window
   import smbgp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SPAN_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              hit,
   output logic [SPAN_W-1:0] ofs
);
   logic [31:0]       base_q;
   logic [ADDR_W-1:0] win_q;
   logic              mapped_q;
   logic [ADDR_W-1:0] rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         win_q    <= '0;
         mapped_q <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_BASE_REG) begin
            base_q <= cfg_wdata;
         end else if (cfg_addr == CFG_MAP_REG && cfg_wdata == MAP_KEY) begin
            win_q    <= ADDR_W'(base_q + WIN_OFFSET);
            mapped_q <= 1'b1;
         end
      end
   end

   assign rel = io_addr - win_q;
   assign hit = mapped_q && (rel[ADDR_W-1:SPAN_W] == '0);
   assign ofs = rel[SPAN_W-1:0];
endmodule

// File: rtl/smbgp_sync.sv
module smbgp_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   logic [LINES-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '1;
         end else if (s == 0) begin
            chain[s] <= din;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/smbgp_regs.sv
module smbgp_regs
   import smbgp_pkg::*;
#(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  byte_sel_e        sel,
   input  logic [7:0]       wdata,
   input  logic [LINES-1:0] sensed,
   output logic [7:0]       sense_q,
   output logic [7:0]       out_q,
   output logic [7:0]       dir_q,
   output logic [7:0]       spare_q
);
   localparam int CAP_DLY = STAGES + 1;
   localparam int CNT_W   = $clog2(CAP_DLY + 1);

   logic [7:0]       cur;
   logic             eff;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      unique case (sel)
         SEL_SENSE: cur = sense_q;
         SEL_OUT:   cur = out_q;
         SEL_DIR:   cur = dir_q;
         default:   cur = spare_q;
      endcase
   end

   assign eff = wr_en && (sel != SEL_SENSE) && (wdata != cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '0;
         spare_q <= '0;
      end else if (eff) begin
         unique case (sel)
            SEL_OUT:   out_q   <= wdata;
            SEL_DIR:   dir_q   <= wdata;
            SEL_SPARE: spare_q <= wdata;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         sense_q <= '0;
      end else if (eff) begin
         cnt_q <= CNT_W'(CAP_DLY);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            sense_q <= 8'(sensed);
         end
      end
   end
endmodule

// File: rtl/smbus_gpio_port.sv
module smbus_gpio_port
   import smbgp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SPAN_W = 3,
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_we,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              io_hit,
   input  logic [LINES-1:0]  line_in,
   output logic [LINES-1:0]  line_oe
);
   if (ADDR_W <= SPAN_W || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must exceed SPAN_W and be at most 32");
   end
   if (SPAN_W < 3) begin : g_bad_span
      $error("SPAN_W must be at least 3");
   end
   if (LINES < 1 || LINES > 8) begin : g_bad_lines
      $error("LINES must be 1 to 8");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic              win_hit;
   logic [SPAN_W-1:0] win_ofs;
   logic              in_regs;
   logic [LINES-1:0]  sensed;
   logic [7:0]        sense_b, out_b, dir_b, spare_b;
   byte_sel_e         sel;

   smbgp_window #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_window (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_addr(io_addr), .hit(win_hit), .ofs(win_ofs)
   );

   smbgp_sync #(.LINES(LINES), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(sensed)
   );

   assign in_regs = win_ofs[SPAN_W-1:2] == '0;
   assign sel     = byte_sel_e'(win_ofs[1:0]);

   smbgp_regs #(.LINES(LINES), .STAGES(STAGES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(io_we && win_hit && in_regs),
      .sel(sel), .wdata(io_wdata), .sensed(sensed),
      .sense_q(sense_b), .out_q(out_b), .dir_q(dir_b), .spare_q(spare_b)
   );

   always_comb begin
      io_rdata = 8'h00;
      if (io_rd && win_hit) begin
         if (!in_regs) begin
            io_rdata = 8'hFF;
         end else begin
            unique case (sel)
               SEL_SENSE: io_rdata = sense_b;
               SEL_OUT:   io_rdata = out_b;
               SEL_DIR:   io_rdata = dir_b;
               default:   io_rdata = spare_b;
            endcase
         end
      end
   end

   assign io_hit = win_hit;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign line_oe[i] = dir_b[i] & ~out_b[i];
   end
endmodule

// File: rtl/smbgp_chk.sv
module smbgp_chk #(
   parameter int ADDR_W = 32,
   parameter int SPAN_W = 3,
   parameter int LINES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_rd,
   input logic              io_we,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              io_hit,
   input logic [LINES-1:0]  line_oe,
   input logic [SPAN_W-1:0] win_ofs,
   input logic [7:0]        out_b,
   input logic [7:0]        dir_b
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (line_oe == '0 && !io_hit);
      end
   end

   assert_out_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && io_hit && win_ofs == SPAN_W'(1)) |=> out_b == $past(io_wdata));

   assert_same_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && io_hit && win_ofs == SPAN_W'(1) && io_wdata == out_b) |=> $stable(out_b));

   assert_sda_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && io_hit && win_ofs == SPAN_W'(2) && !io_wdata[0]) |=> !line_oe[0]);

   assert_hole_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_hit && win_ofs[SPAN_W-1:2] != '0) |-> io_rdata == 8'hFF);

   assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_hit |-> io_rdata == 8'h00);

   assert_miss_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && !io_hit) |=> ($stable(out_b) && $stable(dir_b)));
endmodule

bind smbus_gpio_port smbgp_chk #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .LINES(LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_we(io_we), .io_wdata(io_wdata),
   .io_rdata(io_rdata), .io_hit(io_hit), .line_oe(line_oe), .win_ofs(win_ofs),
   .out_b(out_b), .dir_b(dir_b)
);

// File: tb/test_smbus_gpio_port.sv
module test_smbus_gpio_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_we = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_hit;
   logic [1:0]  line_in;
   logic [1:0]  line_oe;
   logic [1:0]  ext_low = 2'b00;
   logic        mon_oe = 1'b0;
   bit          done = 1'b0;

   int errors = 0;
   int checks = 0;

   typedef struct {
      int         req;
      bit         is_oe;
      logic [8:0] exp;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   assign line_in = ~line_oe & ~ext_low;

   smbus_gpio_port i_smbus_gpio_port (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_rd(io_rd), .io_we(io_we),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
      .line_in(line_in), .line_oe(line_oe)
   );

   task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic wr(input logic [31:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      io_we = 1'b1; io_addr = a; io_wdata = d;
      @(posedge clk); #1;
      io_we = 1'b0;
   endtask

   task automatic rd(input int req, input logic [31:0] a, input logic hit, input logic [7:0] d);
      item_t it;
      @(posedge clk); #1;
      it.req = req; it.is_oe = 1'b0; it.exp = {hit, d};
      sb.push_back(it);
      io_rd = 1'b1; io_addr = a;
      @(posedge clk); #1;
      io_rd = 1'b0;
   endtask

   task automatic chk_oe(input int req, input logic [1:0] d);
      item_t it;
      @(posedge clk); #1;
      it.req = req; it.is_oe = 1'b1; it.exp = {7'd0, d};
      sb.push_back(it);
      mon_oe = 1'b1;
      @(posedge clk); #1;
      mon_oe = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         if (io_rd || mon_oe) begin
            item_t it;
            logic [8:0] act;
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL scoreboard empty: act %h exp none", {io_hit, io_rdata});
            end else begin
               it = sb.pop_front();
               act = it.is_oe ? {7'd0, line_oe} : {io_hit, io_rdata};
               if (act !== it.exp) begin
                  errors++;
                  $display("FAIL R%0d: act %h exp %h", it.req, act, it.exp);
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: act running exp done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 R10: unmapped after reset, lines released
      rd(1, 32'h1038, 1'b0, 8'h00);
      chk_oe(1, 2'b00);
      // R2: map at base+0x38
      cfg_wr(8'h40, 32'h1000);
      cfg_wr(8'h44, 32'h11);
      rd(1, 32'h1038, 1'b1, 8'h00);
      rd(1, 32'h1039, 1'b1, 8'h00);
      rd(1, 32'h103A, 1'b1, 8'h00);
      // R6 R7: both outputs low
      wr(32'h103A, 8'h03);
      chk_oe(6, 2'b11);
      settle();
      rd(8, 32'h1038, 1'b1, 8'h00);
      wr(32'h1039, 8'h01);
      chk_oe(6, 2'b10);
      settle();
      rd(8, 32'h1038, 1'b1, 8'h01);
      wr(32'h1039, 8'h03);
      chk_oe(7, 2'b00);
      settle();
      rd(8, 32'h1038, 1'b1, 8'h03);
      // R8: external pull without write does not refresh
      ext_low = 2'b01;
      settle();
      rd(8, 32'h1038, 1'b1, 8'h03);
      // R5: same value write is not effective
      wr(32'h1039, 8'h03);
      settle();
      rd(5, 32'h1038, 1'b1, 8'h03);
      wr(32'h1039, 8'h07);
      settle();
      rd(8, 32'h1038, 1'b1, 8'h02);
      rd(3, 32'h1039, 1'b1, 8'h07);
      ext_low = 2'b00;
      // R4: sense byte read-only
      wr(32'h1038, 8'h55);
      settle();
      rd(4, 32'h1038, 1'b1, 8'h02);
      // R6: input direction on SDA keeps it released
      wr(32'h103A, 8'h02);
      wr(32'h1039, 8'h06);
      chk_oe(6, 2'b00);
      wr(32'h1039, 8'h04);
      chk_oe(7, 2'b10);
      wr(32'h103A, 8'h00);
      chk_oe(7, 2'b00);
      rd(3, 32'h103A, 1'b1, 8'h00);
      wr(32'h103B, 8'hA5);
      rd(3, 32'h103B, 1'b1, 8'hA5);
      // R9: hole offsets
      rd(9, 32'h103C, 1'b1, 8'hFF);
      wr(32'h103D, 8'h12);
      rd(9, 32'h103D, 1'b1, 8'hFF);
      rd(9, 32'h1039, 1'b1, 8'h04);
      // R10: outside range
      rd(10, 32'h1040, 1'b0, 8'h00);
      rd(10, 32'h1037, 1'b0, 8'h00);
      wr(32'h1041, 8'h99);
      rd(10, 32'h1039, 1'b1, 8'h04);
      // R2: non-key value and late base change
      cfg_wr(8'h44, 32'h10);
      rd(2, 32'h1039, 1'b1, 8'h04);
      cfg_wr(8'h40, 32'h2000);
      rd(2, 32'h1039, 1'b1, 8'h04);
      cfg_wr(8'h44, 32'h11);
      rd(2, 32'h2039, 1'b1, 8'h04);
      rd(2, 32'h1039, 1'b0, 8'h00);
      settle();
      if (sb.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL scoreboard leftover: act %0d exp 0", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule